// File: doc/BRIEF.md
# Dual-Modulus Prescaler from Divide-by-2/3 Cells

This block divides a stream of input-clock enables by either 2^N or 2^N+1, picked one output period at a time by a single modulus control. It is a cascade of N identical divide-by-2/3 cells. Each cell holds a toggling register `b` whose inverted value is fed back, so it halves the rate of the enable it receives. It also holds a one-bit stretch flag `y`. When a cell is told to stretch while `b` is high and `y` is clear, `b` stays high for one more enabled step and `y` is set. On the step after that, `y` clears and `b` falls. A cell that stretches therefore has a three-step period. Each later cell is enabled by the falling edge of the cell before it, so every stage runs at a lower rate than the one feeding it.

Only the first cell ever stretches. Its stretch request is the modulus control gated by the condition that every later cell holds `b` high. That condition lasts for exactly one first-cell period per output period, so at most one input cycle is added per output period. The same condition drives a sample-window output, which tells the controller when it may change the modulus. While the window is low, the modulus is being used and must be held steady.

The model is synchronous logic in the input clock domain. The `ce_in` input marks which clock cycles count as input cycles.

Top module: `dual_mod_prescaler`

## Requirements
- R1: While reset is asserted and right after it, `div_out` is 0, `ctl_window` is 1, and every cell has `b`=0 and `y`=0. The first output period is counted from the first enabled cycle after reset is released.
- R2: If `mod_ctl` is 0 while `ctl_window` is low, the output period is 2^N enabled input cycles (8 for the default N=3).
- R3: If `mod_ctl` is 1 while `ctl_window` is low, the output period is 2^N+1 enabled input cycles (9 for the default N=3).
- R4: Holding `mod_ctl` at 1 for many periods adds exactly one input cycle to each output period, never more than one.
- R5: Changes of `mod_ctl` made while `ctl_window` is high do not affect the period that is running. Only the value held during the window-low stretch of that period counts.
- R6: Clock cycles with `ce_in`=0 do not advance the divider. While `ce_in` stays 0, `div_out` stays 0 and `ctl_window` does not change.
- R7: `div_out` is a one-cycle pulse, registered one clock after the enabled cycle that completes an output period, and it occurs exactly once per period.
- R8: In every cell, an enabled step with `b`=0 sets `b`. An enabled step with `y`=1 clears both `y` and `b`. `y`=1 only while `b`=1. A cell does not change state without an enable.
- R9: `ctl_window` is low only while every cell after the first holds `b`=1. Each output period contains exactly 2 (modulus 2^N) or 3 (modulus 2^N+1) enabled cycles with `ctl_window` low, and they are the last cycles of that period. The controller must keep `mod_ctl` stable while the window is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the input domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in | input | 1 | Marks an input cycle that the divider counts |
| mod_ctl | input | 1 | 1 selects 2^N+1 for the current period, 0 selects 2^N |
| div_out | output | 1 | One-cycle pulse per output period |
| ctl_window | output | 1 | High while a change of `mod_ctl` is safe |

## Verification
On every cycle, the assertions check the cell state rules: the stretch flag releases and `b` falls on the step after a stretch, `b` rises from low, and state holds without an enable. They also check that no period holds more than one stretch, that every completed period is 2^N or 2^N+1 enabled cycles long, and that `mod_ctl` is stable inside the window-low stretch. Whether a given control pattern gives the right period only shows in the bench scenarios. The bench checks that a value set during the window is the one that counts and that edits made earlier have no effect. It also checks that idle cycles are ignored and that the window-low span is 2 or 3 enabled cycles.

// File: rtl/dmp_pkg.sv
`timescale 1ns/1ps
package dmp_pkg;

  typedef struct packed {
    logic b;
    logic y;
  } cell_state_t;

  localparam cell_state_t CELL_RESET = '{b: 1'b0, y: 1'b0};

  // Output period length in enabled input cycles for n cells.
  function automatic int period_len(input int n, input logic extend);
    return (1 << n) + (extend ? 1 : 0);
  endfunction

  // Enabled cycles spent with the window low inside one period.
  function automatic int window_low_len(input logic extend);
    return 2 + (extend ? 1 : 0);
  endfunction

endpackage

// File: rtl/dmp_cell.sv
`timescale 1ns/1ps
module dmp_cell
  import dmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic con_i,
  output logic fire_o,
  output logic stretch_o,
  output logic b_o
);

  cell_state_t st_q;
  cell_state_t st_d;

  // A stretch is taken only from a high b with the flag clear.
  assign stretch_o = en_i & st_q.b & ~st_q.y & con_i;
  // b falls on this enabled step: the cell completes its period.
  assign fire_o    = en_i & st_q.b & ~stretch_o;
  assign b_o       = st_q.b;

  always_comb begin
    st_d = st_q;
    if (en_i) begin
      if (stretch_o) begin
        st_d.y = 1'b1;
      end else begin
        st_d.y = 1'b0;
        st_d.b = ~st_q.b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CELL_RESET;
    else        st_q <= st_d;
  end

  // R8
  y_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && st_q.y) |=> (!st_q.y && !st_q.b));
  // R8
  y_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.y |-> st_q.b);
  // R8
  low_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !st_q.b) |=> st_q.b);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(st_q));

endmodule

// File: rtl/dmp_modgate.sv
`timescale 1ns/1ps
module dmp_modgate #(
  parameter int HI_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] hi_b,
  input  logic            mod_ctl,
  output logic            con0,
  output logic            window
);

  logic hi_all;

  assign hi_all = &hi_b;
  assign con0   = mod_ctl & hi_all;
  assign window = ~hi_all;

  // R9
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!window && $past(!window)) |-> $stable(mod_ctl));

endmodule

// File: rtl/dual_mod_prescaler.sv
`timescale 1ns/1ps
module dual_mod_prescaler
  import dmp_pkg::*;
#(
  parameter int N_STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in,
  input  logic mod_ctl,
  output logic div_out,
  output logic ctl_window
);

  localparam int PMAX = (1 << N_STAGES) + 1;
  localparam int CW   = $clog2(PMAX + 1);

  logic [N_STAGES:0]   en_chain;
  logic [N_STAGES-1:0] b_vec;
  logic [N_STAGES-1:0] stretch_vec;
  logic [N_STAGES-1:0] con_vec;
  logic                con_first;
  logic                period_done;
  logic                div_q;

  assign en_chain[0] = ce_in;

  genvar k;
  generate
    for (k = 0; k < N_STAGES; k++) begin : g_cell
      if (k == 0) begin : g_first
        assign con_vec[k] = con_first;
      end else begin : g_rest
        assign con_vec[k] = 1'b0;
      end
      dmp_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_chain[k]),
        .con_i    (con_vec[k]),
        .fire_o   (en_chain[k+1]),
        .stretch_o(stretch_vec[k]),
        .b_o      (b_vec[k])
      );
    end
  endgenerate

  dmp_modgate #(.HI_W(N_STAGES-1)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .hi_b   (b_vec[N_STAGES-1:1]),
    .mod_ctl(mod_ctl),
    .con0   (con_first),
    .window (ctl_window)
  );

  assign period_done = en_chain[N_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= period_done;
  end
  assign div_out = div_q;

  // Assertion support: enabled cycles and stretches in the current period.
  logic [CW-1:0] cyc_q;
  logic          str_seen_q;
  logic          any_stretch;
  assign any_stretch = |stretch_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q      <= '0;
      str_seen_q <= 1'b0;
    end else if (ce_in) begin
      if (period_done) begin
        cyc_q      <= '0;
        str_seen_q <= 1'b0;
      end else begin
        cyc_q      <= cyc_q + 1'b1;
        str_seen_q <= str_seen_q | any_stretch;
      end
    end
  end

  // R4
  one_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stretch |-> !str_seen_q);
  // R2 R3
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> ((int'(cyc_q) + 1 == period_len(N_STAGES, 1'b0)) ||
                     (int'(cyc_q) + 1 == period_len(N_STAGES, 1'b1))));
  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);
  // R1
  window_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> ctl_window);

endmodule

// File: tb/sim_dual_mod_prescaler.sv
`timescale 1ns/1ps
module sim_dual_mod_prescaler;

  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_in = 1'b1;
  logic mod_ctl = 1'b0;
  logic div_out;
  logic ctl_window;

  int compared = 0;
  int mismatched = 0;
  int ce_mode = 0;   // 0 dense, 1 gaps, 2 idle
  int exp_q[$];
  int cnt_en = 0;
  int cnt_win = 0;
  logic prev_div = 1'b0;

  always #2 clk = ~clk;

  dual_mod_prescaler #(.N_STAGES(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .mod_ctl(mod_ctl),
    .div_out(div_out), .ctl_window(ctl_window)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // ce driver
  initial begin
    forever begin
      @(posedge clk); #1;
      case (ce_mode)
        0: ce_in = 1'b1;
        1: ce_in = ($urandom_range(0, 3) != 0);
        default: ce_in = 1'b0;
      endcase
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (div_out) begin
          int m;
          chk(!prev_div, "R7 pulse width", int'(prev_div), 0);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected pulse", 1, 0);
          end else begin
            m = exp_q.pop_front();
            chk(cnt_en == (2 ** NS) + m, m ? "R3 period" : "R2 period",
                cnt_en, (2 ** NS) + m);
            chk(cnt_win == 2 + m, "R9 window-low span", cnt_win, 2 + m);
          end
          cnt_en = 0;
          cnt_win = 0;
        end
        prev_div = div_out;
        if (ce_in) begin
          cnt_en++;
          if (!ctl_window) cnt_win++;
        end
      end
    end
  end

  task automatic wait_pulse();
    do begin
      @(posedge clk); #1;
    end while (!div_out);
  endtask

  // Called right after a pulse (or reset): window is high here.
  task automatic do_period(input int m, input bit wiggle);
    if (wiggle) begin
      mod_ctl = ~m[0];   // R5: edit while window high
      @(posedge clk); #1;
    end
    mod_ctl = m[0];
    exp_q.push_back(m);
    wait_pulse();
  endtask

  task automatic run_all();
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(div_out == 1'b0, "R1 div_out in reset", int'(div_out), 0);
    chk(ctl_window == 1'b1, "R1 window in reset", int'(ctl_window), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(div_out == 1'b0, "R1 div_out after reset", int'(div_out), 0);
    chk(ctl_window == 1'b1, "R1 window after reset", int'(ctl_window), 1);
    @(posedge clk); #1;

    // R2 modulus 2^N
    for (int i = 0; i < 6; i++) do_period(0, 1'b0);
    // R3 R4 held high
    for (int i = 0; i < 8; i++) do_period(1, 1'b0);
    // R5 alternating with edits during the window
    for (int i = 0; i < 12; i++) do_period(i % 3 == 1 ? 1 : 0, 1'b1);
    // R6 gapped enables, random modulus
    ce_mode = 1;
    for (int i = 0; i < 20; i++) do_period(int'($urandom_range(0, 1)), i[0]);

    // R6 idle cycles hold state
    begin
      logic wsave;
      mod_ctl = 1'b1;
      exp_q.push_back(1);
      @(negedge clk);
      ce_mode = 2;
      repeat (2) @(negedge clk);
      wsave = ctl_window;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        chk(div_out == 1'b0, "R6 idle div_out", int'(div_out), 0);
        chk(ctl_window == wsave, "R6 idle window", int'(ctl_window), int'(wsave));
      end
      ce_mode = 0;
      wait_pulse();
    end
    for (int i = 0; i < 4; i++) do_period(i % 2, 1'b1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all periods seen", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule